// File: doc/BRIEF.md
# Half-Duplex Transmit Keying Controller

This block decides when a packet radio transmitter is keyed, what it sends while keyed, and when it lets go. On a channel it shares with others it waits for the carrier to clear. It then counts down a slot timer and makes a random draw against a persistence threshold. It keys only when the draw passes. On a full-duplex channel it keys as soon as a frame is waiting. Once keyed, it sends a preamble of HDLC flag bytes (0x7E), then the frame bytes, then a tail of flags. It holds the tail state until the transmitter reports that it has dropped.

Preamble and tail lengths are given in units of 10 ms and converted to byte counts from the configured bit rate. A calibration request makes the block send zero bytes, for a length scaled by the bit rate, whenever no frame is on the air. The block sends bytes only against a credit count, which the modem FIFO loads. A stalled phase resumes where it stopped.

Top module: `tx_keying_ctrl`

## Requirements
- R1: After reset `tx_state` is 0 (idle), `ptt_req` is 0, `out_valid` is 0 and `keyed_count` is 0.
- R2: `tx_state` encodes idle=0, keyup=1, data=2, tail=3. A keyed burst emits the preamble flags (0x7E), then every pending frame byte in order (`frm_take` pops each one), then the tail flags.
- R3: The preamble length is `cfg_txdelay*cfg_bitrate/800` flag bytes and the tail length is `cfg_txtail*cfg_bitrate/800` flag bytes. A result of zero emits no flags for that phase.
- R4: In half duplex (`cfg_fulldup`=0), a `slot_tick` that sees `chan_free`=0 reloads the slot counter with `cfg_slot`, and the block stays idle.
- R5: In half duplex, a `slot_tick` that sees `chan_free`=1 decrements a slot counter above 1. Otherwise it reloads the counter and keys up if the 8-bit random value is at most `cfg_persist`, so `cfg_persist`=255 always keys. In full duplex, a tick with a frame pending keys at once.
- R6: A `cfg_wr` pulse sets the slot counter to 1, so the next free-channel tick makes the keying decision.
- R7: In tail, a newly pending frame sends the block back to data without emitting further tail flags. After that frame, a full tail is sent.
- R8: Tail returns to idle only when its flags are exhausted and `ptt_on` is 0.
- R9: `cal_req` arms `cal_units*cfg_bitrate/8` zero bytes. These are emitted in idle or in a finished tail. While any remain, no keyup starts.
- R10: `keyed_count` increments by one on each idle-to-keyup transition, and on nothing else.
- R11: A byte is emitted only while the credit, loaded by `credit_ld` from `credit_val`, is nonzero, and each byte uses one credit. A phase's remaining count survives a stall.
- R12: `ptt_req` is 1 exactly while `tx_state` is not idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | New channel parameters written (forces slot counter to 1) |
| cfg_txdelay | input | 8 | Preamble length, 10 ms units |
| cfg_txtail | input | 8 | Tail length, 10 ms units |
| cfg_slot | input | 8 | Slot time in ticks |
| cfg_persist | input | 8 | Persistence threshold |
| cfg_fulldup | input | 1 | Full-duplex operation |
| cfg_bitrate | input | BRW | Channel bit rate |
| slot_tick | input | 1 | Channel access decision strobe |
| chan_free | input | 1 | Carrier-detect status, 1 = channel free |
| ptt_on | input | 1 | Transmitter still keyed |
| credit_ld | input | 1 | Load byte credit |
| credit_val | input | CRW | Byte credit value |
| cal_req | input | 1 | Calibration request |
| cal_units | input | 8 | Calibration length units |
| frm_valid | input | 1 | Frame byte available |
| frm_data | input | 8 | Frame byte |
| frm_take | output | 1 | Frame byte consumed this cycle |
| out_valid | output | 1 | Byte emitted this cycle |
| out_byte | output | 8 | Emitted byte |
| ptt_req | output | 1 | Transmitter key request |
| tx_state | output | 2 | Current state |
| keyed_count | output | KCW | Number of keyups |

## Verification
A full-duplex burst with contiguous frame bytes checks the preamble, data and tail byte counts. A zero preamble and tail checks that the flag phases can vanish. A half-duplex pattern alternates busy and free ticks, which separates the reload on a busy channel from the countdown on a free one. A parameter write tells the forced slot value apart from natural expiry. A credit stall placed inside the tail, with a frame arriving during the stall, shows that counts carry over and that re-entry into data skips the remaining tail. Calibration is requested with a frame already waiting, so the zero fill and the blocking of keyup are both observed.

// File: rtl/tx_keying_ctrl.sv
module tx_keying_ctrl #(
  parameter int BRW = 21,
  parameter int CRW = 16,
  parameter int KCW = 16,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [7:0]     cfg_txdelay,
  input  logic [7:0]     cfg_txtail,
  input  logic [7:0]     cfg_slot,
  input  logic [7:0]     cfg_persist,
  input  logic           cfg_fulldup,
  input  logic [BRW-1:0] cfg_bitrate,
  input  logic           slot_tick,
  input  logic           chan_free,
  input  logic           ptt_on,
  input  logic           credit_ld,
  input  logic [CRW-1:0] credit_val,
  input  logic           cal_req,
  input  logic [7:0]     cal_units,
  input  logic           frm_valid,
  input  logic [7:0]     frm_data,
  output logic           frm_take,
  output logic           out_valid,
  output logic [7:0]     out_byte,
  output logic           ptt_req,
  output logic [1:0]     tx_state,
  output logic [KCW-1:0] keyed_count
);
  localparam int PW = BRW + 8;
  localparam logic [1:0] S_IDLE = 2'd0, S_KEYUP = 2'd1, S_DATA = 2'd2, S_TAIL = 2'd3;
  localparam logic [7:0] FLAG = 8'h7E;

  logic [1:0]     st;
  logic [PW-1:0]  flag_cnt, cal_cnt;
  logic [7:0]     slot_cnt;
  logic [CRW-1:0] credit;
  logic [15:0]    lfsr;
  logic [KCW-1:0] kcnt;

  logic [PW-1:0] dly_flags, tail_flags, cal_len;
  assign dly_flags  = (PW'(cfg_txdelay) * PW'(cfg_bitrate)) / PW'(800);
  assign tail_flags = (PW'(cfg_txtail) * PW'(cfg_bitrate)) / PW'(800);
  assign cal_len    = (PW'(cal_units) * PW'(cfg_bitrate)) >> 3;

  logic has_credit, cal_slot, emit_flag, emit_data, emit_cal;
  assign has_credit = credit != '0;
  assign cal_slot   = (st == S_IDLE) || (st == S_TAIL && flag_cnt == '0 && !frm_valid);
  assign emit_flag  = has_credit && flag_cnt != '0 &&
                      (st == S_KEYUP || (st == S_TAIL && !frm_valid));
  assign emit_data  = has_credit && st == S_DATA && frm_valid;
  assign emit_cal   = has_credit && cal_cnt != '0 && cal_slot && !emit_flag;

  assign out_valid = emit_flag | emit_data | emit_cal;
  assign out_byte  = emit_data ? frm_data : (emit_flag ? FLAG : 8'h00);
  assign frm_take  = emit_data;

  logic access_ok, half_go, key_go;
  assign access_ok = slot_tick && st == S_IDLE && cal_cnt == '0 && frm_valid;
  assign half_go   = chan_free && slot_cnt <= 8'd1 && lfsr[7:0] <= cfg_persist;
  assign key_go    = access_ok && (cfg_fulldup || half_go);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= LFSR_SEED;
    end else begin
      lfsr <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_cnt <= 8'd1;
    end else if (cfg_wr) begin
      slot_cnt <= 8'd1;
    end else if (access_ok && !cfg_fulldup) begin
      if (!chan_free)            slot_cnt <= cfg_slot;
      else if (slot_cnt > 8'd1)  slot_cnt <= slot_cnt - 8'd1;
      else                       slot_cnt <= cfg_slot;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      credit <= '0;
    end else if (credit_ld) begin
      credit <= credit_val;
    end else if (out_valid) begin
      credit <= credit - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cal_cnt <= '0;
    end else if (cal_req) begin
      cal_cnt <= cal_len;
    end else if (emit_cal) begin
      cal_cnt <= cal_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      flag_cnt <= '0;
      kcnt     <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (key_go) begin
            st       <= S_KEYUP;
            flag_cnt <= dly_flags;
            kcnt     <= kcnt + 1'b1;
          end
        end
        S_KEYUP: begin
          if (flag_cnt == '0)  st <= S_DATA;
          else if (emit_flag)  flag_cnt <= flag_cnt - 1'b1;
        end
        S_DATA: begin
          if (!frm_valid) begin
            st       <= S_TAIL;
            flag_cnt <= tail_flags;
          end
        end
        default: begin
          if (frm_valid) begin
            st       <= S_DATA;
            flag_cnt <= '0;
          end else if (flag_cnt != '0) begin
            if (emit_flag) flag_cnt <= flag_cnt - 1'b1;
          end else if (!ptt_on) begin
            st <= S_IDLE;
          end
        end
      endcase
    end
  end

  assign ptt_req     = st != S_IDLE;
  assign tx_state    = st;
  assign keyed_count = kcnt;
endmodule

// File: rtl/tx_keying_ctrl_chk.sv
module tx_keying_ctrl_chk #(
  parameter int CRW = 16,
  parameter int KCW = 16,
  parameter int PW  = 29
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     st,
  input logic [CRW-1:0] credit,
  input logic [PW-1:0]  cal_cnt,
  input logic [KCW-1:0] kcnt,
  input logic           credit_ld,
  input logic           out_valid,
  input logic [7:0]     out_byte,
  input logic           frm_valid,
  input logic           frm_take,
  input logic           ptt_on
);
  a_r11_credit_use: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !credit_ld) |=> credit == $past(credit) - 1'b1);

  a_r10_keyed_incr: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0) |=> (kcnt == $past(kcnt) + 1'b1) == (st == 2'd1));

  a_r8_tail_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3 && ptt_on) |=> st != 2'd0);

  a_r9_cal_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && cal_cnt != '0) |=> st == 2'd0);

  a_r2_keyup_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && out_valid) |-> out_byte == 8'h7E);

  a_r7_tail_reenter: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3 && frm_valid) |=> st == 2'd2);

  a_r2_data_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && out_valid) |-> frm_take);
endmodule

bind tx_keying_ctrl tx_keying_ctrl_chk #(.CRW(CRW), .KCW(KCW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .credit(credit), .cal_cnt(cal_cnt),
  .kcnt(kcnt), .credit_ld(credit_ld), .out_valid(out_valid), .out_byte(out_byte),
  .frm_valid(frm_valid), .frm_take(frm_take), .ptt_on(ptt_on));

// File: tb/tx_keying_ctrl_test.sv
module tx_keying_ctrl_test;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic cfg_wr = 0, cfg_fulldup = 1, slot_tick = 0, chan_free = 1, ptt_on = 1;
  logic [7:0] cfg_txdelay = 2, cfg_txtail = 3, cfg_slot = 1, cfg_persist = 255;
  logic [20:0] cfg_bitrate = 21'd1600;
  logic credit_ld = 0, cal_req = 0;
  logic [15:0] credit_val = 0;
  logic [7:0] cal_units = 0;
  logic frm_valid, frm_take, out_valid, ptt_req;
  logic [7:0] frm_data, out_byte;
  logic [1:0] tx_state;
  logic [15:0] keyed_count;

  logic [7:0] q [0:63];
  int qwr = 0, qrd = 0;
  assign frm_valid = qrd < qwr;
  assign frm_data  = q[qrd[5:0]];
  always @(posedge clk) if (frm_take) qrd <= qrd + 1;

  logic [7:0] lg [0:511];
  int nlog = 0;
  always @(negedge clk) if (rst_n && out_valid) begin lg[nlog] = out_byte; nlog++; end

  tx_keying_ctrl uut (.*);

  int checks = 0, failures = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin failures++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask
  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask
  task automatic run(input int n); repeat (n) @(negedge clk); endtask
  task automatic push(input logic [7:0] b); q[qwr[5:0]] = b; qwr++; endtask
  task automatic load_credit(input int v);
    credit_val = 16'(v); credit_ld = 1; run(1); credit_ld = 0;
  endtask
  task automatic tick; slot_tick = 1; run(1); slot_tick = 0; endtask
  task automatic do_reset;
    rst_n = 0; slot_tick = 0; cal_req = 0; cfg_wr = 0; ptt_on = 1; chan_free = 1;
    cfg_fulldup = 1; cfg_txdelay = 2; cfg_txtail = 3; cfg_slot = 1; cfg_persist = 255;
    run(2); qwr = 0; qrd = 0; nlog = 0; rst_n = 1; run(1);
  endtask
  task automatic seq_flags(input string req, input int from, input int n);
    for (int i = from; i < from + n; i++) eq(req, lg[i], 8'h7E);
  endtask

  task automatic t_reset;
    do_reset;
    eq("R1", tx_state, 0); eq("R1", ptt_req, 0); eq("R1", out_valid, 0); eq("R1", keyed_count, 0);
  endtask

  task automatic t_full_burst;
    do_reset; load_credit(1000);
    push(8'hA1); push(8'hA2); push(8'hA3);
    slot_tick = 1; run(40); slot_tick = 0;
    eq("R3", nlog, 13);
    seq_flags("R2", 0, 4);
    eq("R2", lg[4], 8'hA1); eq("R2", lg[5], 8'hA2); eq("R2", lg[6], 8'hA3);
    seq_flags("R3", 7, 6);
    eq("R8", tx_state, 3); eq("R12", ptt_req, 1); eq("R10", keyed_count, 1);
    ptt_on = 0; run(2);
    eq("R8", tx_state, 0); eq("R12", ptt_req, 0);
  endtask

  task automatic t_zero_len;
    do_reset; cfg_txdelay = 0; cfg_txtail = 0; load_credit(100);
    push(8'h66); slot_tick = 1; run(10); slot_tick = 0;
    eq("R3", nlog, 1); eq("R3", lg[0], 8'h66); eq("R8", tx_state, 3);
  endtask

  task automatic t_half_duplex;
    do_reset; cfg_fulldup = 0; cfg_slot = 3; chan_free = 0; load_credit(100);
    push(8'h42);
    tick; tick; tick;
    eq("R4", tx_state, 0); eq("R4", nlog, 0);
    chan_free = 1; tick; tick;
    eq("R5", tx_state, 0);
    tick;
    eq("R5", tx_state, 1); eq("R10", keyed_count, 1);
  endtask

  task automatic t_cfg_write;
    do_reset; cfg_fulldup = 0; cfg_slot = 5; chan_free = 0; load_credit(100);
    push(8'h43); tick; chan_free = 1;
    cfg_wr = 1; run(1); cfg_wr = 0;
    tick;
    eq("R6", tx_state, 1);
  endtask

  task automatic t_tail_reentry;
    do_reset; push(8'h11); load_credit(7);
    slot_tick = 1; run(30);
    eq("R11", nlog, 7); eq("R11", lg[4], 8'h11); seq_flags("R11", 5, 2);
    eq("R11", tx_state, 3);
    push(8'h22); push(8'h33); run(3);
    eq("R7", tx_state, 2); eq("R11", nlog, 7);
    load_credit(100); run(30); slot_tick = 0;
    eq("R7", nlog, 15); eq("R7", lg[7], 8'h22); eq("R7", lg[8], 8'h33);
    seq_flags("R7", 9, 6);
    eq("R10", keyed_count, 1);
  endtask

  task automatic t_calibration;
    int zeros;
    do_reset;
    cal_units = 1; cal_req = 1; run(1); cal_req = 0;
    push(8'h55); slot_tick = 1; load_credit(1000);
    run(100);
    eq("R9", keyed_count, 0); eq("R9", tx_state, 0);
    run(150); slot_tick = 0;
    zeros = 0;
    for (int i = 0; i < 200; i++) if (lg[i] == 8'h00) zeros++;
    eq("R9", zeros, 200); eq("R9", nlog, 211);
    eq("R9", lg[200], 8'h7E); eq("R9", lg[204], 8'h55); eq("R10", keyed_count, 1);
  endtask

  initial begin
    fork
      begin
        t_reset; t_full_burst; t_zero_len; t_half_duplex;
        t_cfg_write; t_tail_reentry; t_calibration;
      end
      begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule